// File: doc/BRIEF.md
# Double-to-Single Narrowing with Half-Precision Tie Correction

This block narrows an IEEE 754 double-precision bit pattern to a single-precision pattern. That single is meant to be rounded to half precision by a later stage. If each of the two steps rounds to nearest-even on its own, the half result can differ from a direct double-to-half rounding. A tie can be lost, or a tie can be created where none existed. In nearest-even mode the block fixes this by adjusting two bits of the single: the bit that the half stage will use as its guard, and the single's least significant bit, which the half stage folds into its sticky. In toward-zero mode the block returns the truncated single without any adjustment.

Each input sample is sorted into one of four classes: ZERO, NORMAL, OVERFLOW and SPECIAL. The class is decided only by the double's exponent field. The class selects how the single is formed:
- NORMAL rebiases the exponent and rounds the mantissa.
- OVERFLOW saturates the result.
- ZERO flushes the result to a signed zero.
- SPECIAL forwards an infinity or a quiet NaN.

The class is recomputed for every sample, with no memory from one sample to the next. The corrected single is registered, and it appears one clock after the sample is accepted.

Top module: `dbl2half_prep`

## Requirements
- R1: After reset `valid_out` and `dout` are 0. `valid_out` equals `valid_in` one cycle later. `dout` loads only on a cycle with `valid_in` high and holds its value otherwise.
- R2: `rnd_mode` = 0 selects round to nearest-even. `rnd_mode` = 1 selects round toward zero.
- R3: NORMAL class (double exponent 897..1150). The single exponent is the double exponent minus 896. The single mantissa is double mantissa bits 51:29. In nearest-even mode the mantissa rounds up when bit 28 is set and either bits 27:0 are nonzero or the kept LSB is 1. A carry out of the mantissa increments the exponent, and a carry into exponent 255 gives infinity.
- R4: In toward-zero mode the result is the plain truncation. Bits 28:0 are discarded and no correction is applied.
- R5: OVERFLOW class (double exponent 1151..2046). Nearest-even gives a signed infinity (magnitude 0x7F800000). Toward-zero gives a signed largest finite value (magnitude 0x7F7FFFFF).
- R6: ZERO class (double exponent 0..896, which includes zeros and subnormals). The narrowed value is a signed zero, before any correction.
- R7: SPECIAL class (double exponent 2047). A zero mantissa gives a signed infinity. A nonzero mantissa gives a signed quiet NaN with magnitude 0x7FC00000.
- R8: In nearest-even mode, when the narrowed single is finite and any of double mantissa bits 40:0 is set, bit 0 of `dout` is forced to 1.
- R9: In nearest-even mode, when the narrowed single is finite and double mantissa bit 41 is clear, bit 12 of `dout` is forced to 0. When bit 41 is set, bit 12 keeps its narrowed value.
- R10: A narrowed single that is infinity or NaN (exponent field 255) is never corrected.
- R11: In nearest-even mode, rounding `dout` to half precision with nearest-even gives the same result as rounding the input double directly. This holds for inputs with double exponent 1009..1038. For example, 0x40EE6A0000000001 gives 0x7B9B and 0x40EFFDFFFFFFFFFF gives 0x7BFF.
- R12: The sign bit of `dout` always equals the sign bit of the accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Input sample qualifier |
| rnd_mode | input | 1 | Rounding select: 0 = nearest-even, 1 = toward zero |
| din | input | 64 | Double-precision bit pattern |
| valid_out | output | 1 | High one cycle after an accepted sample |
| dout | output | 32 | Corrected single-precision bit pattern |

## Verification
The assertions assume three things about the inputs:
- `rnd_mode` and `din` hold defined values on every cycle where `valid_in` is high.
- The reset is asserted before the first sample.
- An input is judged against the output of the very next cycle, with no sample dropped in between.

The bench keeps to these conditions. It changes inputs only on the falling edge and holds `valid_in` high for a single cycle per sample. It always drives `rnd_mode` to 0 or 1. For the chained half-precision comparison, it draws random and tie-shaped doubles only from the exponent band where the half result is normal or overflows, so both half references stay in their defined range.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    // Class of the incoming double, decided from its exponent field alone
    typedef enum logic [1:0] {
        CL_ZERO    = 2'd0,
        CL_NORMAL  = 2'd1,
        CL_OVER    = 2'd2,
        CL_SPECIAL = 2'd3
    } src_class_e;

    typedef enum logic {
        RM_NEAREST_EVEN = 1'b0,
        RM_TOWARD_ZERO  = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
    import fpn_pkg::*;
#(
    parameter int SRC_EXP = 11,
    parameter int DST_EXP = 8
) (
    input  logic [SRC_EXP-1:0] exp_i,
    output src_class_e         cls_o
);
    localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
    localparam int REBIAS   = SRC_BIAS - DST_BIAS;
    localparam int LO_NORM  = REBIAS + 1;
    localparam int HI_NORM  = REBIAS + (1 << DST_EXP) - 2;
    localparam int SRC_TOP  = (1 << SRC_EXP) - 1;

    always_comb begin
        if (exp_i == SRC_EXP'(SRC_TOP))
            cls_o = CL_SPECIAL;
        else if (exp_i > SRC_EXP'(HI_NORM))
            cls_o = CL_OVER;
        else if (exp_i < SRC_EXP'(LO_NORM))
            cls_o = CL_ZERO;
        else
            cls_o = CL_NORMAL;
    end

endmodule

// File: rtl/fpn_round.sv
module fpn_round
    import fpn_pkg::*;
#(
    parameter int SRC_EXP = 11,
    parameter int SRC_MAN = 52,
    parameter int DST_EXP = 8,
    parameter int DST_MAN = 23
) (
    input  logic                       sign_i,
    input  logic [DST_EXP-1:0]         exp_lo_i,
    input  logic [SRC_MAN-1:0]         man_i,
    input  src_class_e                 cls_i,
    input  rnd_mode_e                  mode_i,
    output logic [DST_EXP+DST_MAN:0]   res_o
);
    localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
    localparam int REBIAS   = SRC_BIAS - DST_BIAS;
    localparam int DROP     = SRC_MAN - DST_MAN;
    localparam int MAG_W    = DST_EXP + DST_MAN;
    localparam logic [MAG_W-1:0] INF_MAG = {{DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
    localparam logic [MAG_W-1:0] MAX_FIN = INF_MAG - MAG_W'(1);
    localparam logic [MAG_W-1:0] QNAN    = INF_MAG | (MAG_W'(1) << (DST_MAN - 1));

    logic [DST_EXP-1:0] exp_d;
    logic [MAG_W-1:0]   trunc_mag;
    logic               guard, sticky, round_up;
    logic [MAG_W-1:0]   mag;

    // Modular rebias: only the low exponent bits matter inside the normal band
    assign exp_d     = exp_lo_i - DST_EXP'(REBIAS);
    assign trunc_mag = {exp_d, man_i[SRC_MAN-1 -: DST_MAN]};
    assign guard     = man_i[DROP-1];
    assign sticky    = |man_i[DROP-2:0];
    assign round_up  = (mode_i == RM_NEAREST_EVEN) && guard && (sticky || trunc_mag[0]);

    always_comb begin
        mag = '0;
        unique case (cls_i)
            CL_ZERO:    mag = '0;
            CL_NORMAL:  mag = trunc_mag + MAG_W'(round_up);
            CL_OVER:    mag = (mode_i == RM_TOWARD_ZERO) ? MAX_FIN : INF_MAG;
            CL_SPECIAL: mag = (|man_i) ? QNAN : INF_MAG;
        endcase
    end

    assign res_o = {sign_i, mag};

endmodule

// File: rtl/fpn_tiefix.sv
module fpn_tiefix
    import fpn_pkg::*;
#(
    parameter int SRC_MAN = 52,
    parameter int DST_EXP = 8,
    parameter int DST_MAN = 23,
    parameter int FIN_MAN = 10
) (
    input  rnd_mode_e                        mode_i,
    input  logic [SRC_MAN-FIN_MAN-1:0]       man_lo_i,
    input  logic [DST_EXP+DST_MAN:0]         narrowed_i,
    output logic [DST_EXP+DST_MAN:0]         fixed_o
);
    localparam int SRC_TIE = SRC_MAN - FIN_MAN - 1;
    localparam int DST_TIE = DST_MAN - FIN_MAN - 1;

    logic finite;
    logic apply_fix;

    assign finite    = ~&narrowed_i[DST_EXP+DST_MAN-1 -: DST_EXP];
    assign apply_fix = (mode_i == RM_NEAREST_EVEN) && finite;

    always_comb begin
        fixed_o = narrowed_i;
        if (apply_fix) begin
            // carry lost low-order evidence into the single's sticky region
            if (|man_lo_i[SRC_TIE-1:0])
                fixed_o[0] = 1'b1;
            // a tie may exist in the single only where the double had one
            if (!man_lo_i[SRC_TIE])
                fixed_o[DST_TIE] = 1'b0;
        end
    end

endmodule

// File: rtl/dbl2half_prep.sv
module dbl2half_prep
    import fpn_pkg::*;
#(
    parameter int SRC_EXP = 11,
    parameter int SRC_MAN = 52,
    parameter int DST_EXP = 8,
    parameter int DST_MAN = 23,
    parameter int FIN_MAN = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid_in,
    input  logic                       rnd_mode,
    input  logic [SRC_EXP+SRC_MAN:0]   din,
    output logic                       valid_out,
    output logic [DST_EXP+DST_MAN:0]   dout
);
    localparam int SRC_W   = 1 + SRC_EXP + SRC_MAN;
    localparam int DST_W   = 1 + DST_EXP + DST_MAN;
    localparam int SRC_TIE = SRC_MAN - FIN_MAN - 1;
    localparam int DST_TIE = DST_MAN - FIN_MAN - 1;

    src_class_e          cls_w;
    rnd_mode_e           mode_w;
    logic [DST_W-1:0]    narrowed_w;
    logic [DST_W-1:0]    fixed_w;
    logic [DST_W-1:0]    dout_q;
    logic                valid_q;

    assign mode_w = rnd_mode_e'(rnd_mode);

    fpn_classify #(.SRC_EXP(SRC_EXP), .DST_EXP(DST_EXP)) u_classify (
        .exp_i (din[SRC_W-2 -: SRC_EXP]),
        .cls_o (cls_w)
    );

    fpn_round #(
        .SRC_EXP(SRC_EXP), .SRC_MAN(SRC_MAN),
        .DST_EXP(DST_EXP), .DST_MAN(DST_MAN)
    ) u_round (
        .sign_i   (din[SRC_W-1]),
        .exp_lo_i (din[SRC_MAN +: DST_EXP]),
        .man_i    (din[SRC_MAN-1:0]),
        .cls_i    (cls_w),
        .mode_i   (mode_w),
        .res_o    (narrowed_w)
    );

    fpn_tiefix #(
        .SRC_MAN(SRC_MAN), .DST_EXP(DST_EXP),
        .DST_MAN(DST_MAN), .FIN_MAN(FIN_MAN)
    ) u_tiefix (
        .mode_i     (mode_w),
        .man_lo_i   (din[SRC_TIE:0]),
        .narrowed_i (narrowed_w),
        .fixed_o    (fixed_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            dout_q  <= '0;
        end else begin
            valid_q <= valid_in;
            if (valid_in)
                dout_q <= fixed_w;
        end
    end

    assign valid_out = valid_q;
    assign dout      = dout_q;

    // R1: output holds between samples
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(dout));

    // R12: sign follows the accepted input
    p_sign_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> dout[DST_W-1] == $past(din[SRC_W-1]));

    // R4: toward-zero normal samples keep the upper mantissa bits untouched
    p_trunc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && rnd_mode && cls_w == CL_NORMAL)
        |=> dout[DST_MAN-1:0] == $past(din[SRC_MAN-1 -: DST_MAN]));

    // R7: NaN input yields a quiet NaN
    p_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && cls_w == CL_SPECIAL && |din[SRC_MAN-1:0])
        |=> (&dout[DST_W-2 -: DST_EXP]) && dout[DST_MAN-1]);

    // R8: low-order evidence survives in the LSB of a finite result
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !rnd_mode && |din[SRC_TIE-1:0])
        |=> (&dout[DST_W-2 -: DST_EXP]) || dout[0]);

    // R9: no tie bit in a finite result unless the double had one
    p_tie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !rnd_mode && !din[SRC_TIE])
        |=> (&dout[DST_W-2 -: DST_EXP]) || !dout[DST_TIE]);

endmodule

// File: tb/dbl2half_prep_bench.sv
module dbl2half_prep_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        rnd_mode = 1'b0;
    logic [63:0] din = '0;
    logic        valid_out;
    logic [31:0] dout;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dbl2half_prep u_dbl2half_prep (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .rnd_mode  (rnd_mode),
        .din       (din),
        .valid_out (valid_out),
        .dout      (dout)
    );

    // ---------------- reference models ----------------
    function automatic logic [31:0] ref_single(input logic [63:0] d, input logic rtz);
        int          e;
        logic [51:0] m;
        logic [31:0] r;
        logic [30:0] mag;
        e = int'(d[62:52]);
        m = d[51:0];
        if (e == 2047)
            return (m != 0) ? {d[63], 31'h7FC00000} : {d[63], 31'h7F800000};
        if (e < 897)
            r = {d[63], 31'd0};
        else if (e > 1150)
            r = {d[63], rtz ? 31'h7F7FFFFF : 31'h7F800000};
        else begin
            mag = 31'((e - 896) * (1 << 23)) | 31'(m >> 29);
            if (!rtz && m[28] && ((m[27:0] != 0) || mag[0]))
                mag = mag + 31'd1;
            r = {d[63], mag};
        end
        if (!rtz && r[30:23] != 8'hFF) begin
            if (m[40:0] != 0) r[0] = 1'b1;
            if (!m[41])       r[12] = 1'b0;
        end
        return r;
    endfunction

    // half nearest-even from sign, biased half exponent (>=1) and 52-bit fraction
    function automatic logic [15:0] ref_half(input logic s, input int hexp, input logic [51:0] m);
        logic [15:0] v;
        if (hexp >= 31) return {s, 15'h7C00};
        v = {1'b0, hexp[4:0], m[51:42]};
        if (m[41] && ((m[40:0] != 0) || v[0]))
            v = v + 16'd1;
        return {s, v[14:0]};
    endfunction

    function automatic logic [15:0] half_of_double(input logic [63:0] d);
        return ref_half(d[63], int'(d[62:52]) - 1008, d[51:0]);
    endfunction

    function automatic logic [15:0] half_of_single(input logic [31:0] f);
        return ref_half(f[31], int'(f[30:23]) - 112, {f[22:0], 29'd0});
    endfunction

    // ---------------- helpers ----------------
    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] d, input logic m);
        @(negedge clk);
        din      = d;
        rnd_mode = m;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic expect_ref(input string tag, input logic [63:0] d, input logic m);
        apply(d, m);
        check32(tag, dout, ref_single(d, m));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check32("R1 reset dout", dout, 32'h0);
        check32("R1 reset valid_out", {31'd0, valid_out}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_valid_hold;
        apply(64'h3FF0000000000000, 1'b0);
        check32("R1 valid_out after sample", {31'd0, valid_out}, 32'd1);
        check32("R3 one", dout, 32'h3F800000);
        din = 64'hC000000000000000;
        @(negedge clk);
        check32("R1 valid_out idle", {31'd0, valid_out}, 32'd0);
        check32("R1 dout held", dout, 32'h3F800000);
    endtask

    task automatic t_normal;
        expect_ref("R3 pi nearest", 64'h400921FB54442D18, 1'b0);
        expect_ref("R3 carry into exponent", 64'h3FFFFFFFF0000000, 1'b0);
        apply(64'h3FFFFFFFF0000000, 1'b0);
        check32("R3 carry constant", dout, 32'h40000001);
        apply(64'h47EFFFFFF0000000, 1'b0);
        check32("R3 carry to infinity", dout, 32'h7F800000);
    endtask

    task automatic t_rtz;
        expect_ref("R4 pi toward zero", 64'h400921FB54442D18, 1'b1);
        apply(64'h3FF0000000000001, 1'b1);
        check32("R4 R2 no sticky fix", dout, 32'h3F800000);
        apply(64'h3FF0000000000001, 1'b0);
        check32("R2 nearest gets sticky", dout, 32'h3F800001);
    endtask

    task automatic t_overflow;
        apply(64'h47F0000000000000, 1'b0);
        check32("R5 overflow nearest", dout, 32'h7F800000);
        apply(64'hC7F0000000000000, 1'b1);
        check32("R5 overflow toward zero", dout, 32'hFF7FFFFF);
    endtask

    task automatic t_underflow;
        apply(64'h3800000000000000, 1'b0);
        check32("R6 below single range", dout, 32'h00000000);
        apply(64'h8000000000000001, 1'b1);
        check32("R6 subnormal toward zero", dout, 32'h80000000);
        apply(64'h0000000000000001, 1'b0);
        check32("R6 R8 zero with sticky", dout, 32'h00000001);
    endtask

    task automatic t_special;
        apply(64'h7FF0000000000000, 1'b0);
        check32("R7 infinity", dout, 32'h7F800000);
        apply(64'hFFF8000000000000, 1'b0);
        check32("R7 negative NaN", dout, 32'hFFC00000);
        apply(64'h7FF0000000000001, 1'b0);
        check32("R10 NaN not corrected", dout, 32'h7FC00000);
        apply(64'h47F0000000000001, 1'b0);
        check32("R10 overflow infinity not corrected", dout, 32'h7F800000);
    endtask

    task automatic t_sticky_tie;
        apply(64'h3FF0000000000000 | (64'h1FFF << 28), 1'b0);
        check32("R9 carry-made tie cleared", dout, 32'h3F800001);
        apply(64'h3FF0020000000000, 1'b0);
        check32("R9 true tie kept", dout, 32'h3F801000);
        apply(64'h3FF0000000000400, 1'b0);
        check32("R8 deep sticky", dout, 32'h3F800001);
    endtask

    task automatic t_sign;
        apply(64'hBFF0000000000000, 1'b0);
        check32("R12 negative one", dout, 32'hBF800000);
    endtask

    task automatic t_known;
        apply(64'h40EE6A0000000001, 1'b0);
        check32("R11 lost tie case", {16'd0, half_of_single(dout)}, 32'h00007B9B);
        apply(64'h40EFFDFFFFFFFFFF, 1'b0);
        check32("R11 spurious tie case", {16'd0, half_of_single(dout)}, 32'h00007BFF);
    endtask

    task automatic t_chain_random;
        for (int i = 0; i < 300; i++) begin
            logic [51:0] m;
            logic [10:0] e;
            logic [63:0] d;
            m = {$urandom, $urandom} & 52'hF_FFFF_FFFF_FFFF;
            e = 11'(1009 + int'($urandom_range(29, 0)));
            if (i >= 150) begin
                case (i % 3)
                    0: m[40:0] = '0;
                    1: m[40:0] = 41'd1;
                    default: begin
                        m[40:28] = '1;
                        m[27:0]  = 28'($urandom_range(1, 0));
                    end
                endcase
            end
            d = {1'($urandom_range(1, 0)), e, m};
            apply(d, 1'b0);
            check32("R3 random narrowing", dout, ref_single(d, 1'b0));
            check32("R11 chained half", {16'd0, half_of_single(dout)},
                    {16'd0, half_of_double(d)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_valid_hold();
        t_normal();
        t_rtz();
        t_overflow();
        t_underflow();
        t_special();
        t_sticky_tie();
        t_sign();
        t_known();
        t_chain_random();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule